// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block merges up to 32 device request lines into a single interrupt output for a processor. Each line owns one bit in a pending-status register. When a line requests service, its bit is set. The bit then stays set until software clears it. Software reads the status register to learn which device group raised the request, so it only has to search that group for the device that needs service.

A mask register decides which pending bits reach the interrupt output. Lines 0 and 1 are permanently enabled. Software clears pending bits in one of two ways:
- a direct write to the status register;
- a write-one-to-clear acknowledge register, which removes selected bits atomically with no read-modify-write.

A parameter chooses how requests are captured. Level capture re-sets a bit for as long as its line is high. Edge capture sets a bit only on a rising edge. Request lines pass through a synchronizer before capture. The register port is a plain synchronous read/write port, and read data appears one cycle after the read strobe.

Top module: `irq_hub`

## Requirements
- R1: After reset, the mask register reads 0x3, the status register reads 0, the acknowledge register reads 0 and `irq_o` is low. The address map is: 0 = mask, 1 = status, 2 = acknowledge, 3 = reserved (reads 0).
- R2: An asserted request line i sets status bit i. The bit stays set after the line drops, until software clears it.
- R3: With edge capture, a status bit is set only by a low-to-high transition of its line. A line held high does not set the bit again after it has been acknowledged.
- R4: With level capture, acknowledging a bit whose line is still high leaves the bit set.
- R5: A write to the status register loads the written data OR-ed with the requests captured in that cycle. With level capture, these are all currently asserted lines. With edge capture, these are only the rising edges seen in that cycle.
- R6: Writing the acknowledge register clears every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged. The acknowledge register itself reads as 0.
- R7: `irq_o` is high exactly when some status bit is set and its effective mask bit is 1. Status bits whose effective mask bit is 0 do not drive `irq_o`.
- R8: Mask bits 0 and 1 are always effective and always read back as 1, whatever value is written to them.
- R9: A request captured in the same cycle as an acknowledge or status write to the same bit wins, and the bit ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Device request lines, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select (0 mask, 1 status, 2 acknowledge) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The delicate case is a new request capture landing in the same cycle as a software acknowledge or direct status write to that bit. The bench provokes it by raising a line exactly two clock edges before the register write, so the synchronized edge meets the write strobe. The status register is then read back, and the bit must still be set. Both capture variants are instantiated side by side under identical stimulus, and each has its own expected value. This exposes where the variants diverge: a held line re-setting a bit, and a direct status write discarding a captured edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   // Register select codes; the software driver depends on these values.
   typedef enum logic [1:0] {
      RA_MASK = 2'd0,
      RA_STAT = 2'd1,
      RA_ACK  = 2'd2,
      RA_RSVD = 2'd3
   } reg_addr_e;

   // Number of low request lines that can never be masked.
   localparam int unsigned ALWAYS_ON = 2;

   // Minimum synchronizer depth accepted by the block.
   localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int k = 1; k < int'(STAGES); k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
   parameter int unsigned WIDTH     = 32,
   parameter bit          EDGE_MODE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] req_s_i,
   output logic [WIDTH-1:0] set_o
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic [WIDTH-1:0] prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= req_s_i;
         end

         assign set_o = req_s_i & ~prev_q;

         // R3: a set request must come from a line that was low one cycle earlier
         p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_o) |-> ((set_o & $past(req_s_i)) == '0));
      end else begin : g_level
         assign set_o = req_s_i;
      end
   endgenerate

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic               reg_we_i,
   input  logic               reg_re_i,
   input  logic [1:0]         reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic [NUM_SRC-1:0] status_o,
   output logic [NUM_SRC-1:0] eff_mask_o
);

   reg_addr_e          addr_e;
   logic               wr_mask, wr_stat, wr_ack;
   logic [NUM_SRC-1:0] wsrc;
   logic [NUM_SRC-1:0] force_on;
   logic [NUM_SRC-1:0] mask_q, mask_d;
   logic [NUM_SRC-1:0] status_q, status_d;
   logic [DATA_W-1:0]  rdata_q, rdata_d;

   assign addr_e  = reg_addr_e'(reg_addr_i);
   assign wr_mask = reg_we_i && (addr_e == RA_MASK);
   assign wr_stat = reg_we_i && (addr_e == RA_STAT);
   assign wr_ack  = reg_we_i && (addr_e == RA_ACK);
   assign wsrc    = reg_wdata_i[NUM_SRC-1:0];

   always_comb begin
      force_on = '0;
      force_on[ALWAYS_ON-1:0] = '1;
   end

   assign eff_mask_o = mask_q | force_on;

   // Mask storage: plain load on write.
   always_comb begin
      mask_d = mask_q;
      if (wr_mask) mask_d = wsrc;
   end

   // Status update: captured requests are OR-ed in last, so they win over any clear.
   always_comb begin
      status_d = status_q;
      if (wr_stat)     status_d = wsrc;
      else if (wr_ack) status_d = status_q & ~wsrc;
      status_d = status_d | set_i;
   end

   // Read mux, registered.
   always_comb begin
      rdata_d = rdata_q;
      if (reg_re_i) begin
         rdata_d = '0;
         case (addr_e)
            RA_MASK: rdata_d[NUM_SRC-1:0] = eff_mask_o;
            RA_STAT: rdata_d[NUM_SRC-1:0] = status_q;
            default: rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         status_q <= '0;
         rdata_q  <= '0;
      end else begin
         mask_q   <= mask_d;
         status_q <= status_d;
         rdata_q  <= rdata_d;
      end
   end

   assign status_o    = status_q;
   assign reg_rdata_o = rdata_q;

   // R6: acknowledged bits without a concurrent capture are gone next cycle
   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> ((status_q & $past(wsrc & ~set_i)) == '0));

   // R2: with no software write, pending bits never drop
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat && !wr_ack) |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R9: any captured request is present in status the next cycle
   p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

   // R8: low mask bits always read as one
   p_low_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re_i && addr_e == RA_MASK) |=> (reg_rdata_o[1:0] == 2'b11));

   // R6: acknowledge register reads back as zero
   p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re_i && addr_e == RA_ACK) |=> (reg_rdata_o == '0));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EDGE_MODE   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               reg_we_i,
   input  logic               reg_re_i,
   input  logic [1:0]         reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               irq_o
);

   generate
      if (NUM_SRC < ALWAYS_ON || NUM_SRC > DATA_W) begin : g_bad_width
         $error("irq_hub: NUM_SRC must lie between 2 and DATA_W");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("irq_hub: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_SRC-1:0] req_s;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] status;
   logic [NUM_SRC-1:0] eff_mask;

   irq_hub_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (req_i),
      .sync_o  (req_s)
   );

   irq_hub_capture #(
      .WIDTH     (NUM_SRC),
      .EDGE_MODE (EDGE_MODE)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s_i (req_s),
      .set_o   (set_vec)
   );

   irq_hub_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_vec),
      .reg_we_i    (reg_we_i),
      .reg_re_i    (reg_re_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .status_o    (status),
      .eff_mask_o  (eff_mask)
   );

   assign irq_o = |(status & eff_mask);

   // R8: a pending bit on line 0 or 1 always raises the interrupt
   p_low_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|status[1:0]) |-> irq_o);

   // R7: with nothing pending the interrupt stays low
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq_o);

endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
   import irq_hub_pkg::*;

   localparam time CLK_PERIOD = 10ns;
   localparam int  N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          we = 1'b0;
   logic          re = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rd_l, rd_e;
   logic          irq_l, irq_e;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   string       tag_q[$];
   logic [31:0] exl_q[$];
   logic [31:0] exe_q[$];
   logic        rd_pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_hub #(.NUM_SRC(N), .DATA_W(32), .SYNC_STAGES(2), .EDGE_MODE(1'b0)) u_irq_hub (
      .clk(clk), .rst_n(rst_n), .req_i(req), .reg_we_i(we), .reg_re_i(re),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_l), .irq_o(irq_l));

   irq_hub #(.NUM_SRC(N), .DATA_W(32), .SYNC_STAGES(2), .EDGE_MODE(1'b1)) u_irq_hub_edge (
      .clk(clk), .rst_n(rst_n), .req_i(req), .reg_we_i(we), .reg_re_i(re),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_e), .irq_o(irq_e));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected read data once registered data is available.
   always @(posedge clk) rd_pend <= re;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (tag_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: got %h expected none", rd_l);
         end else begin
            string       t;
            logic [31:0] el, ee;
            t  = tag_q.pop_front();
            el = exl_q.pop_front();
            ee = exe_q.pop_front();
            chk({t, " level"}, rd_l, el);
            chk({t, " edge"},  rd_e, ee);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] el, input logic [31:0] ee,
                     input string tag);
      @(negedge clk);
      re = 1'b1; addr = a;
      tag_q.push_back(tag); exl_q.push_back(el); exe_q.push_back(ee);
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic chk_irq(input logic el, input logic ee, input string tag);
      @(negedge clk);
      chk({tag, " irq level"}, {31'd0, irq_l}, {31'd0, el});
      chk({tag, " irq edge"},  {31'd0, irq_e}, {31'd0, ee});
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic set_req(input int idx, input logic v);
      @(negedge clk);
      req[idx] = v;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state and address map
      chk_irq(1'b0, 1'b0, "R1");
      rd(RA_MASK, 32'h3, 32'h3, "R1 mask");
      rd(RA_STAT, 32'h0, 32'h0, "R1 status");
      rd(RA_ACK,  32'h0, 32'h0, "R1 ack");
      rd(RA_RSVD, 32'h0, 32'h0, "R1 reserved");

      // R2/R7: capture on line 5 while masked
      set_req(5, 1'b1); settle();
      rd(RA_STAT, 32'h20, 32'h20, "R2 capture");
      chk_irq(1'b0, 1'b0, "R7 masked");
      wr(RA_MASK, 32'h20);
      chk_irq(1'b1, 1'b1, "R7 enabled");
      rd(RA_MASK, 32'h23, 32'h23, "R8 mask readback");

      // R2: sticky after line drops
      set_req(5, 1'b0); settle();
      rd(RA_STAT, 32'h20, 32'h20, "R2 sticky");
      wr(RA_ACK, 32'h20);
      rd(RA_STAT, 32'h0, 32'h0, "R6 ack clear");
      chk_irq(1'b0, 1'b0, "R7 cleared");

      // R3/R4: held line acknowledged
      set_req(5, 1'b1); settle();
      wr(RA_ACK, 32'h20);
      rd(RA_STAT, 32'h20, 32'h0, "R4 R3 held line");

      // R8: lines 0/1 cannot be masked
      set_req(5, 1'b0); set_req(0, 1'b1);
      wr(RA_MASK, 32'h0); settle();
      rd(RA_MASK, 32'h3, 32'h3, "R8 forced bits");
      rd(RA_STAT, 32'h21, 32'h01, "R2 line0");
      chk_irq(1'b1, 1'b1, "R8 line0 unmasked");
      wr(RA_ACK, 32'hFFFF_FFFF);
      rd(RA_STAT, 32'h01, 32'h0, "R4 R3 ack all");
      chk_irq(1'b1, 1'b0, "R8 after ack");
      set_req(0, 1'b0); settle();
      wr(RA_ACK, 32'hFFFF_FFFF);
      rd(RA_STAT, 32'h0, 32'h0, "R6 empty");

      // R5: direct status write
      set_req(2, 1'b1); settle();
      rd(RA_STAT, 32'h04, 32'h04, "R2 line2");
      wr(RA_STAT, 32'h100);
      rd(RA_STAT, 32'h104, 32'h100, "R5 write merge");
      wr(RA_ACK, 32'h04);
      rd(RA_STAT, 32'h104, 32'h100, "R6 zero bits kept");

      // R9: capture coinciding with acknowledge
      set_req(2, 1'b0); settle();
      wr(RA_STAT, 32'h0); settle();
      rd(RA_STAT, 32'h0, 32'h0, "R5 clear by write");
      set_req(3, 1'b1);
      @(posedge clk); @(posedge clk);
      wr(RA_ACK, 32'h08);
      rd(RA_STAT, 32'h08, 32'h08, "R9 ack race");
      // R9: capture coinciding with a status write
      set_req(4, 1'b1);
      @(posedge clk); @(posedge clk);
      wr(RA_STAT, 32'h0);
      rd(RA_STAT, 32'h18, 32'h10, "R9 write race");
      chk_irq(1'b0, 1'b0, "R7 high bits masked");

      repeat (3) @(negedge clk);
      if (tag_q.size() != 0) begin
         n_vec++; n_bad++;
         $display("FAIL scoreboard: got %0d pending expected 0", tag_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule